// File: doc/BRIEF.md
# Data-Path Checksum Sniffer

The sniffer watches the stream of data beats that a multi-channel transfer engine writes. It folds into one 32-bit accumulator every beat that comes from a single chosen channel, and it does so only when that channel's own sniff-enable bit is set. Software picks the channel and the algorithm through a control register. The algorithms are a reflected CRC-32, a CRC-16-CCITT, a bit-reversed-input companion for each CRC, a parity reduction and a wrapping sum. The result is read back through a data register.

The accumulator does not clear between transfers. It keeps gathering across any number of runs until software writes the data register, and that write loads the written value. A write to the control register loads the initial value of the newly chosen algorithm. A beat is folded one byte at a time, starting at the least significant byte, and only the bytes its size covers take part.

Top module: `beat_sniffer`

## Requirements
- R1: After reset the accumulator reads 0 and the control register is cleared: sniffing disabled, channel 0, mode 0.
- R2: A control-register write (regAddr = 0) sets enable from bit 0, the channel from bits 4:1 and the mode from bits 8:5. It also loads the accumulator with the mode's initial value: 0xFFFFFFFF for modes 0 and 1, 0x0000FFFF for modes 2 and 3, and 0 for every other mode.
- R3: A beat is folded only when beatValid is high, beatSniffEn is high, sniffing is enabled, and beatChan equals the selected channel. Any other beat leaves the value read back unchanged.
- R4: Mode 0 is CRC-32 with the reflected polynomial 0xEDB88320. Each byte is fed in least significant bit first, and no final inversion is applied. Folding the ASCII string "123456789" from the initial value reads back 0x340BC6D9.
- R5: Mode 1 is the same as mode 0, and mode 3 is the same as mode 2, except that the bit order of each input byte is reversed before it is folded.
- R6: Mode 2 is CRC-16-CCITT with polynomial 0x1021. Each byte is fed most significant bit first. Folding "123456789" from the initial value reads back 0x000029B1. In modes 2 and 3 bits 31:16 of the value read back are 0.
- R7: Mode 4 (parity) sets the accumulator to bit 0 of the accumulator XOR-ed with every bit of the covered bytes, with bits 31:1 cleared.
- R8: Mode 5 adds the covered bytes, taken as an unsigned value, to the accumulator modulo 2^32.
- R9: beatSize 0 covers byte 0, 1 covers bytes 1:0, and 2 or 3 covers all four bytes. CRC modes process the covered bytes from byte 0 upward.
- R10: A data-register write (regAddr = 1) loads the accumulator with the written value. The accumulator keeps its value across any number of beats and transfers until the next register write.
- R11: A register write in the same cycle as a qualifying beat takes priority, and that beat is dropped.
- R12: Modes 6 to 15 leave the accumulator unchanged on beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| beatValid | input | 1 | A write beat is present this cycle |
| beatData | input | 32 | Beat data |
| beatSize | input | 2 | Beat size: 0 byte, 1 halfword, 2 or 3 word |
| beatChan | input | CH_W (4) | Channel issuing the beat |
| beatSniffEn | input | 1 | Sniff-enable bit of the issuing channel |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 control register, 1 data register |
| regWrData | input | 32 | Register write data |
| sniffData | output | 32 | Accumulator value read back |

## Verification
The hardest case to reach is a register write that lands in the very cycle a qualifying beat is folded. The bench drives both on the same falling edge and expects the written value, not the folded one. Correct CRC arithmetic is also hard to show from the ports alone. The bench checks it two ways: a multi-beat run of "123456789" mixing word and byte beats must land on the published CRC residues, and a sweep covers every mode, every size and several data patterns, each compared against a bit-serial model in the bench.

// File: rtl/sniff_pkg.sv
package sniff_pkg;
  localparam int ACC_W = 32;
  localparam int LANES = ACC_W / 8;
  localparam int MODE_LSB = 5;
  localparam int MODE_W = 4;
  localparam logic [31:0] CRC32_POLY = 32'hEDB88320;
  localparam logic [15:0] CRC16_POLY = 16'h1021;

  localparam logic [MODE_W-1:0] MODE_CRC32     = 4'd0;
  localparam logic [MODE_W-1:0] MODE_CRC32_REV = 4'd1;
  localparam logic [MODE_W-1:0] MODE_CRC16     = 4'd2;
  localparam logic [MODE_W-1:0] MODE_CRC16_REV = 4'd3;
  localparam logic [MODE_W-1:0] MODE_PARITY    = 4'd4;
  localparam logic [MODE_W-1:0] MODE_SUM       = 4'd5;

  typedef struct packed {
    logic              load;   // data register write
    logic              seed;   // control register write
    logic              fold;   // qualified beat
    logic [ACC_W-1:0]  value;  // value for load or seed
    logic [MODE_W-1:0] mode;
    logic [1:0]        size;
    logic [ACC_W-1:0]  beat;
  } sniff_op_t;

  function automatic logic [7:0] revByte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] crc32Byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] x;
    x = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ CRC32_POLY) : (x >> 1);
    return x;
  endfunction

  function automatic logic [15:0] crc16Byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) x = x[15] ? ((x << 1) ^ CRC16_POLY) : (x << 1);
    return x;
  endfunction

  function automatic logic [31:0] seedFor(input logic [MODE_W-1:0] m);
    logic [31:0] s;
    case (m)
      MODE_CRC32, MODE_CRC32_REV: s = 32'hFFFF_FFFF;
      MODE_CRC16, MODE_CRC16_REV: s = 32'h0000_FFFF;
      default:                    s = 32'h0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sniff_ctrl.sv
module sniff_ctrl
  import sniff_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beatValid,
  input  logic [ACC_W-1:0] beatData,
  input  logic [1:0]       beatSize,
  input  logic [CH_W-1:0]  beatChan,
  input  logic             beatSniffEn,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [ACC_W-1:0] regWrData,
  output sniff_op_t        op
);
  // channel field occupies bits CH_W:1, which must stay below the mode field
  logic              enQ;
  logic [CH_W-1:0]   chanQ;
  logic [MODE_W-1:0] modeQ;
  logic              ctrlWr;
  logic              dataWr;
  logic [MODE_W-1:0] newMode;

  assign ctrlWr  = regWrEn && !regAddr;
  assign dataWr  = regWrEn && regAddr;
  assign newMode = regWrData[MODE_LSB +: MODE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      chanQ <= '0;
      modeQ <= '0;
    end else if (ctrlWr) begin
      enQ   <= regWrData[0];
      chanQ <= regWrData[CH_W:1];
      modeQ <= newMode;
    end
  end

  always_comb begin
    op.load  = dataWr;
    op.seed  = ctrlWr;
    op.value = dataWr ? regWrData : seedFor(newMode);
    op.fold  = beatValid && beatSniffEn && enQ && (beatChan == chanQ) && !regWrEn;
    op.mode  = modeQ;
    op.size  = beatSize;
    op.beat  = beatData;
  end

  a_r3_foreign_channel: assert property (@(posedge clk) disable iff (!rstN)
    (beatChan != chanQ) |-> !op.fold);
  a_r11_write_blocks_fold: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !op.fold);
endmodule

// File: rtl/sniff_datapath.sv
module sniff_datapath
  import sniff_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  sniff_op_t        op,
  output logic [ACC_W-1:0] sniffData
);
  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] byteMask;
  logic [ACC_W-1:0] covered;
  logic [2:0]       laneCnt;
  logic             revMode;
  logic             crc16Mode;
  logic [31:0]      c32 [LANES+1];
  logic [15:0]      c16 [LANES+1];

  assign revMode   = (op.mode == MODE_CRC32_REV) || (op.mode == MODE_CRC16_REV);
  assign crc16Mode = (op.mode == MODE_CRC16) || (op.mode == MODE_CRC16_REV);

  always_comb begin
    case (op.size)
      2'd0:    laneCnt = 3'd1;
      2'd1:    laneCnt = 3'd2;
      default: laneCnt = 3'(LANES);
    endcase
    for (int i = 0; i < LANES; i++)
      byteMask[8*i +: 8] = (3'(i) < laneCnt) ? 8'hFF : 8'h00;
  end

  assign covered = op.beat & byteMask;
  assign c32[0]  = accQ;
  assign c16[0]  = accQ[15:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] laneByte;
    assign laneByte = revMode ? revByte(op.beat[8*g +: 8]) : op.beat[8*g +: 8];
    assign c32[g+1] = crc32Byte(c32[g], laneByte);
    assign c16[g+1] = crc16Byte(c16[g], laneByte);
  end

  always_comb begin
    case (op.mode)
      MODE_CRC32, MODE_CRC32_REV: accNext = c32[laneCnt];
      MODE_CRC16, MODE_CRC16_REV: accNext = {16'h0, c16[laneCnt]};
      MODE_PARITY:                accNext = {31'h0, accQ[0] ^ (^covered)};
      MODE_SUM:                   accNext = accQ + covered;
      default:                    accNext = accQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        accQ <= '0;
    else if (op.load) accQ <= op.value;
    else if (op.seed) accQ <= op.value;
    else if (op.fold) accQ <= accNext;
  end

  assign sniffData = crc16Mode ? {16'h0, accQ[15:0]} : accQ;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!op.load && !op.seed && !op.fold) |=> $stable(accQ));
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    op.load |=> (accQ == $past(op.value)));
  a_r8_sum_word: assert property (@(posedge clk) disable iff (!rstN)
    (op.fold && op.mode == MODE_SUM && op.size == 2'd2) |=> (accQ == $past(accQ) + $past(op.beat)));
  a_r7_parity_width: assert property (@(posedge clk) disable iff (!rstN)
    (op.fold && op.mode == MODE_PARITY) |=> (accQ[31:1] == 31'h0));
  a_r6_crc16_upper: assert property (@(posedge clk) disable iff (!rstN)
    (op.fold && (op.mode == MODE_CRC16 || op.mode == MODE_CRC16_REV)) |=> (accQ[31:16] == 16'h0));
endmodule

// File: rtl/beat_sniffer.sv
module beat_sniffer
  import sniff_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beatValid,
  input  logic [ACC_W-1:0] beatData,
  input  logic [1:0]       beatSize,
  input  logic [CH_W-1:0]  beatChan,
  input  logic             beatSniffEn,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [ACC_W-1:0] regWrData,
  output logic [ACC_W-1:0] sniffData
);
  sniff_op_t op;

  sniff_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatData(beatData),
    .beatSize(beatSize), .beatChan(beatChan), .beatSniffEn(beatSniffEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .op(op)
  );

  sniff_datapath u_dp (
    .clk(clk), .rstN(rstN), .op(op), .sniffData(sniffData)
  );

  a_r3_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !beatSniffEn) |=> $stable(sniffData));
endmodule

// File: tb/beat_sniffer_tb.sv
`timescale 1ns/1ps
module beat_sniffer_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        beatValid = 0;
  logic [31:0] beatData = 0;
  logic [1:0]  beatSize = 0;
  logic [3:0]  beatChan = 0;
  logic        beatSniffEn = 0;
  logic        regWrEn = 0;
  logic        regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] sniffData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] refAcc = 0;
  logic [3:0]  refMode = 0;

  always #10 clk = ~clk;

  beat_sniffer u_dut (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatData(beatData),
    .beatSize(beatSize), .beatChan(beatChan), .beatSniffEn(beatSniffEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .sniffData(sniffData)
  );

  function automatic logic [7:0] flip8(input logic [7:0] b);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[7-j] = b[j];
    return r;
  endfunction

  function automatic logic [31:0] seedOf(input logic [3:0] m);
    if (m <= 1) return 32'hFFFFFFFF;
    if (m <= 3) return 32'h0000FFFF;
    return 0;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] acc, input logic [3:0] m,
                                        input logic [31:0] d, input logic [1:0] sz);
    int n;
    logic [31:0] c;
    logic [31:0] msk;
    logic [7:0] b;
    logic fb;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    msk = (n == 4) ? 32'hFFFFFFFF : ((32'h1 << (8*n)) - 1);
    c = acc;
    case (m)
      0, 1: for (int i = 0; i < n; i++) begin
        b = d[8*i +: 8];
        if (m == 1) b = flip8(b);
        for (int j = 0; j < 8; j++) begin
          fb = c[0] ^ b[j];
          c = c >> 1;
          if (fb) c = c ^ 32'hEDB88320;
        end
      end
      2, 3: begin
        c = {16'h0, acc[15:0]};
        for (int i = 0; i < n; i++) begin
          b = d[8*i +: 8];
          if (m == 3) b = flip8(b);
          for (int j = 7; j >= 0; j--) begin
            fb = c[15] ^ b[j];
            c = {16'h0, c[14:0], 1'b0};
            if (fb) c = c ^ 32'h1021;
          end
        end
      end
      4: c = {31'h0, acc[0] ^ (^(d & msk))};
      5: c = acc + (d & msk);
      default: c = acc;
    endcase
    return c;
  endfunction

  function automatic logic [31:0] view(input logic [31:0] a, input logic [3:0] m);
    return (m == 2 || m == 3) ? {16'h0, a[15:0]} : a;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (sniffData !== exp) begin
      errors++;
      $display("FAIL %s: sniffData=%h expected=%h", tag, sniffData, exp);
    end
  endtask

  task automatic wrCtrl(input logic en, input logic [3:0] ch, input logic [3:0] m);
    @(negedge clk);
    regWrEn = 1; regAddr = 0; regWrData = {23'h0, m, ch, en};
    @(negedge clk);
    regWrEn = 0;
    refMode = m; refAcc = seedOf(m);
  endtask

  task automatic wrData(input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1; regAddr = 1; regWrData = v;
    @(negedge clk);
    regWrEn = 0;
    refAcc = v;
  endtask

  task automatic beat(input logic [31:0] d, input logic [1:0] sz, input logic [3:0] ch, input logic sen);
    @(negedge clk);
    beatValid = 1; beatData = d; beatSize = sz; beatChan = ch; beatSniffEn = sen;
    @(negedge clk);
    beatValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: sniffData=%h expected=done", sniffData);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset value", 32'h0);
    beat(32'hDEADBEEF, 2, 0, 1);
    check("R1 disabled after reset", 32'h0);

    // R4 and R9 known residue, mixing word and byte beats
    wrCtrl(1, 3, 0);
    check("R2 crc32 seed", 32'hFFFFFFFF);
    beat(32'h34333231, 2, 3, 1);
    beat(32'h38373635, 2, 3, 1);
    beat(32'h00000039, 0, 3, 1);
    check("R4 crc32 of 123456789", 32'h340BC6D9);

    // R6 known residue, halfword beats
    wrCtrl(1, 3, 2);
    check("R2 crc16 seed", 32'h0000FFFF);
    beat(32'hAAAA3231, 1, 3, 1);
    beat(32'h55553433, 1, 3, 1);
    beat(32'h38373635, 2, 3, 1);
    beat(32'hFFFFFF39, 0, 3, 1);
    check("R6 crc16 of 123456789", 32'h000029B1);
    wrData(32'h12345678);
    check("R6 upper bits zero", 32'h00005678);

    // sweep: all modes, sizes, patterns; foreign-channel beats ignored
    for (int m = 0; m < 6; m++) begin
      wrCtrl(1, 5, 4'(m));
      check("R2 seed per mode", view(refAcc, refMode));
      for (int sz = 0; sz < 4; sz++) begin
        for (int k = 0; k < 6; k++) begin
          logic [31:0] d;
          d = (32'h9E3779B9 * (k + 1)) ^ (32'h01000193 * (sz + 3 * m));
          beat(d, 2'(sz), 5, 1);
          refAcc = model(refAcc, refMode, d, 2'(sz));
          case (m)
            0: check("R4 R9 crc32 sweep", view(refAcc, refMode));
            1, 3: check("R5 reversed sweep", view(refAcc, refMode));
            2: check("R6 crc16 sweep", view(refAcc, refMode));
            4: check("R7 parity sweep", view(refAcc, refMode));
            default: check("R8 sum sweep", view(refAcc, refMode));
          endcase
          beat(~d, 2'(sz), 4, 1);
          check("R3 other channel ignored", view(refAcc, refMode));
        end
      end
    end

    // R3 sniff-enable low and sniffing disabled
    wrCtrl(1, 7, 5);
    wrData(32'h100);
    beat(32'h55, 2, 7, 0);
    check("R3 sniffEn low ignored", 32'h100);
    wrCtrl(0, 7, 5);
    wrData(32'h200);
    beat(32'h55, 2, 7, 1);
    check("R3 disabled ignored", 32'h200);

    // R10 persistence across transfers
    wrCtrl(1, 7, 5);
    beat(32'h10, 2, 7, 1);
    beat(32'h20, 2, 7, 1);
    repeat (5) @(negedge clk);
    beat(32'h30, 2, 7, 1);
    check("R10 sum persists across runs", 32'h60);
    wrData(32'hFFFFFFF0);
    beat(32'h20, 2, 7, 1);
    check("R10 load then wrap R8", 32'h10);

    // R11 data write and beat in the same cycle
    @(negedge clk);
    beatValid = 1; beatData = 32'h777; beatSize = 2; beatChan = 7; beatSniffEn = 1;
    regWrEn = 1; regAddr = 1; regWrData = 32'hCAFE0000;
    @(negedge clk);
    beatValid = 0; regWrEn = 0;
    check("R11 write wins over beat", 32'hCAFE0000);

    // R12 reserved modes hold value
    for (int m = 6; m < 16; m++) begin
      wrCtrl(1, 2, 4'(m));
      check("R12 reserved seed", 32'h0);
      wrData(32'h0BAD0000 + m);
      beat(32'hFFFFFFFF, 2, 2, 1);
      check("R12 reserved mode unchanged", 32'h0BAD0000 + m);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule